// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block turns three supply-voltage comparator outputs into the chip's internal reset. Each comparator reports that the supply is at or below its own threshold. The primary monitor always forces a reset. The two secondary monitors force a reset only while their enable input is high. Reset is asserted at once and without a clock. How it is released depends on the cause. After a primary-monitor event, the block waits a fixed number of slow-oscillator cycles. After a secondary-monitor event, it waits a stabilization delay plus a fixed tail of CPU clock cycles. Both delays are counted from the moment the triggering comparator output falls.

The block has two reset outputs. The core reset covers pins, CPU and all registers. The retained-register reset is asserted only by power-on and the primary monitor, so state in that domain survives a secondary-monitor reset. The block also holds several pieces of software-visible state:
- a cause/status register;
- a processor-mode field that lives in the retained domain;
- a CPU clock-source select bit, forced to "slow oscillator divided by 8" by every reset.

When the core reset releases, the block issues a one-cycle start-fetch pulse.

Top module: `supply_rst_seq`

## Requirements
- R1: While `mon0_low` is 1, `rst_core_n` and `rst_keep_n` are 0 without waiting for a clock edge, whatever the enable inputs are.
- R2: `mon1_low` (and `mon2_low`) cause no reset and set no status bit while `mon1_en` (`mon2_en`) is 0. When the enable is 1, they drive `rst_core_n` low at once.
- R3: After `mon0_low` falls, `rst_core_n` stays 0 for at least `OSC_CYCLES` (32) periods of `clk_osc`. It rises within a few further cycles.
- R4: After an enabled `mon1_low` or `mon2_low` falls, `rst_core_n` stays 0 for at least `STAB_CYCLES + TAIL_CYCLES` (8 + 60) cycles of `clk_cpu`. It rises within a few further cycles.
- R5: Any reset sets `clk_slow_div8` to 1, and it stays 1 while `rst_core_n` is 0. Out of reset, a write strobe on `clk_sel_wr` loads `clk_sel_d` into it.
- R6: A primary-monitor reset (and power-on) clears `stat_rd` to 000 and `pmode` to 0. In `stat_rd`, bit 0 is the warm-start bit (0 = cold start), bit 1 the secondary-1 flag and bit 2 the secondary-2 flag.
- R7: An enabled secondary-1 reset sets `stat_rd` bit 1, and a secondary-2 reset sets bit 2. Other status bits keep their values.
- R8: `rst_keep_n` stays 1 through a secondary-monitor reset, and `pmode` keeps its value through it.
- R9: Out of reset, a `stat_wr` strobe behaves per bit. On bits 2:1, writing 0 clears a flag and writing 1 has no effect. On bit 0, writing 1 sets the warm-start bit and writing 0 has no effect. A `pm_wr` strobe loads `pmode`. Writes presented while `rst_core_n` is 0 are ignored.
- R10: `start_fetch` pulses high for exactly one `clk_cpu` cycle each time `rst_core_n` rises, and never otherwise.
- R11: A new enabled trigger during a release count restarts the count. The release then comes the full delay after the new trigger falls.
- R12: When the primary and a secondary monitor are active together, the primary takes priority. The status ends cold with both flags clear, and `pmode` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Slow on-chip oscillator clock, counts the primary-monitor release delay |
| clk_cpu | input | 1 | CPU clock, counts the secondary release delay and runs the registers |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mon0_low | input | 1 | Primary comparator, 1 = supply at or below threshold (asynchronous) |
| mon1_low | input | 1 | Secondary comparator 1, 1 = supply at or below threshold (asynchronous) |
| mon2_low | input | 1 | Secondary comparator 2, 1 = supply at or below threshold (asynchronous) |
| mon1_en | input | 1 | Enables reset from secondary comparator 1 |
| mon2_en | input | 1 | Enables reset from secondary comparator 2 |
| clk_sel_wr | input | 1 | Write strobe for the clock-source select bit |
| clk_sel_d | input | 1 | Value written to the clock-source select bit |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 3 | Status write data (bits 2:1 write-0-to-clear, bit 0 write-1-to-set) |
| pm_wr | input | 1 | Write strobe for the processor-mode field |
| pm_wdata | input | PM_W | Processor-mode write data |
| rst_core_n | output | 1 | Reset to pins, CPU and all registers, active low |
| rst_keep_n | output | 1 | Reset to the retained-register domain, active low |
| start_fetch | output | 1 | One-cycle pulse when the core reset releases |
| clk_slow_div8 | output | 1 | 1 = CPU clock taken from slow oscillator divided by 8 |
| stat_rd | output | 3 | Status register: bit 2 secondary-2 flag, bit 1 secondary-1 flag, bit 0 warm start |
| pmode | output | PM_W | Processor-mode field |

## Verification
The bench times each release from the falling edge of the triggering comparator. A release one window too early shows up as an early-release failure. So does a design whose count did not restart on a retrigger, or one that counted from the rising edge of the comparator. A secondary comparator pulsed with its enable low would pull the core reset low or set a flag if the gating were missing. Software writes made while the core is still in reset would change the mode or the status if the write gating were lost. The primary and a secondary monitor are asserted together, and the scoreboard compares the status, mode and clock select at every start-fetch pulse. A design that let the secondary path set a flag, or that kept the mode across the primary reset, therefore fails there.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int STAT_W = 3;

  // Status register layout; field positions are visible to software.
  typedef struct packed {
    logic sec2_hit;  // bit 2
    logic sec1_hit;  // bit 1
    logic warm;      // bit 0, 0 = cold start
  } rsq_stat_t;

  localparam rsq_stat_t STAT_CLEAR = '{sec2_hit: 1'b0, sec1_hit: 1'b0, warm: 1'b0};

endpackage

// File: rtl/rsq_sync.sv
// Multi-stage synchronizer with an asynchronous clear; output is 0 while cleared.
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rsq_cnt.sv
// Saturating delay counter: done rises after LIMIT clocks with go high.
module rsq_cnt #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic arst_n,
  input  logic go,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LIM);
  assign cnt_en = go & ~done;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rsq_status.sv
// Retained-domain state: cause/status register and processor-mode field.
module rsq_status
  import rsq_pkg::*;
#(
  parameter int PM_W = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sw_en,
  input  logic              set_sec1,
  input  logic              set_sec2,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              pm_wr,
  input  logic [PM_W-1:0]   pm_wdata,
  output logic [STAT_W-1:0] stat_rd,
  output logic [PM_W-1:0]   pmode
);

  rsq_stat_t       st_q;
  rsq_stat_t       st_d;
  rsq_stat_t       wr_v;
  logic [PM_W-1:0] pm_q;
  logic [PM_W-1:0] pm_d;

  assign wr_v = rsq_stat_t'(stat_wdata);

  always_comb begin
    st_d = st_q;
    pm_d = pm_q;
    if (sw_en && stat_wr) begin
      st_d.warm     = st_q.warm | wr_v.warm;
      st_d.sec1_hit = st_q.sec1_hit & wr_v.sec1_hit;
      st_d.sec2_hit = st_q.sec2_hit & wr_v.sec2_hit;
    end
    if (set_sec1) begin
      st_d.sec1_hit = 1'b1;
    end
    if (set_sec2) begin
      st_d.sec2_hit = 1'b1;
    end
    if (sw_en && pm_wr) begin
      pm_d = pm_wdata;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q <= STAT_CLEAR;
      pm_q <= '0;
    end else begin
      st_q <= st_d;
      pm_q <= pm_d;
    end
  end

  assign stat_rd = st_q;
  assign pmode   = pm_q;

endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq
  import rsq_pkg::*;
#(
  parameter int OSC_CYCLES  = 32,
  parameter int STAB_CYCLES = 8,
  parameter int TAIL_CYCLES = 60,
  parameter int SYNC_STAGES = 2,
  parameter int PM_W        = 2
) (
  input  logic              clk_osc,
  input  logic              clk_cpu,
  input  logic              por_n,
  input  logic              mon0_low,
  input  logic              mon1_low,
  input  logic              mon2_low,
  input  logic              mon1_en,
  input  logic              mon2_en,
  input  logic              clk_sel_wr,
  input  logic              clk_sel_d,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              pm_wr,
  input  logic [PM_W-1:0]   pm_wdata,
  output logic              rst_core_n,
  output logic              rst_keep_n,
  output logic              start_fetch,
  output logic              clk_slow_div8,
  output logic [STAT_W-1:0] stat_rd,
  output logic [PM_W-1:0]   pmode
);

  localparam int SEC_CYCLES = STAB_CYCLES + TAIL_CYCLES;
  localparam int N_SEC      = 2;

  logic             trig0;
  logic [N_SEC-1:0] trig_sec;
  logic             hold0_n;
  logic             hold_sec_n;
  logic             hold_all_n;

  // Trigger qualification: the primary is unconditional.
  assign trig0       = mon0_low;
  assign trig_sec[0] = mon1_low & mon1_en;
  assign trig_sec[1] = mon2_low & mon2_en;

  assign hold0_n    = por_n & ~trig0;
  assign hold_sec_n = por_n & ~(|trig_sec);
  assign hold_all_n = hold0_n & hold_sec_n;

  // Primary release path: slow-oscillator count, then back to the CPU domain.
  logic osc_go;
  logic osc_done;
  logic done0;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
    .clk(clk_osc), .arst_n(hold0_n), .d(1'b1), .q(osc_go)
  );

  rsq_cnt #(.LIMIT(OSC_CYCLES)) u_cnt_osc (
    .clk(clk_osc), .arst_n(hold0_n), .go(osc_go), .done(osc_done)
  );

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_done0 (
    .clk(clk_cpu), .arst_n(hold0_n), .d(osc_done), .q(done0)
  );

  // Secondary release path: CPU-clock count of stabilization plus tail.
  logic sec_go;
  logic done_sec;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_sec (
    .clk(clk_cpu), .arst_n(hold_sec_n), .d(1'b1), .q(sec_go)
  );

  rsq_cnt #(.LIMIT(SEC_CYCLES)) u_cnt_sec (
    .clk(clk_cpu), .arst_n(hold_sec_n), .go(sec_go), .done(done_sec)
  );

  // Cause detection for the status flags, one synchronizer per secondary.
  logic [N_SEC-1:0] flag_set;

  for (genvar g = 0; g < N_SEC; g++) begin : g_flag_sync
    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_flag (
      .clk(clk_cpu), .arst_n(por_n), .d(trig_sec[g]), .q(flag_set[g])
    );
  end

  // Reset outputs and start pulse.
  logic core_q;
  logic core_d;
  logic core_dly_q;
  logic keep_q;
  logic keep_d;
  logic cksel_q;
  logic cksel_d;

  always_comb begin
    core_d  = done0 & done_sec;
    keep_d  = done0;
    cksel_d = cksel_q;
    if (core_q && clk_sel_wr) begin
      cksel_d = clk_sel_d;
    end
  end

  always_ff @(posedge clk_cpu or negedge hold_all_n) begin
    if (!hold_all_n) begin
      core_q     <= 1'b0;
      core_dly_q <= 1'b0;
      cksel_q    <= 1'b1;
    end else begin
      core_q     <= core_d;
      core_dly_q <= core_q;
      cksel_q    <= cksel_d;
    end
  end

  always_ff @(posedge clk_cpu or negedge hold0_n) begin
    if (!hold0_n) begin
      keep_q <= 1'b0;
    end else begin
      keep_q <= keep_d;
    end
  end

  assign rst_core_n    = core_q;
  assign rst_keep_n    = keep_q;
  assign start_fetch   = core_q & ~core_dly_q;
  assign clk_slow_div8 = cksel_q;

  rsq_status #(.PM_W(PM_W)) u_status (
    .clk        (clk_cpu),
    .arst_n     (hold0_n),
    .sw_en      (core_q),
    .set_sec1   (flag_set[0]),
    .set_sec2   (flag_set[1]),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .pm_wr      (pm_wr),
    .pm_wdata   (pm_wdata),
    .stat_rd    (stat_rd),
    .pmode      (pmode)
  );

endmodule

// File: rtl/supply_rst_seq_chk.sv
module supply_rst_seq_chk #(
  parameter int PM_W = 2
) (
  input logic            clk_cpu,
  input logic            por_n,
  input logic            mon0_low,
  input logic            mon1_low,
  input logic            mon1_en,
  input logic            rst_core_n,
  input logic            rst_keep_n,
  input logic            start_fetch,
  input logic            clk_slow_div8,
  input logic [2:0]      stat_rd,
  input logic [PM_W-1:0] pmode
);

  AST_PRIMARY_HOLDS: assert property (@(posedge clk_cpu) disable iff (!por_n)
    mon0_low |-> (!rst_core_n && !rst_keep_n)); // R1

  AST_SEC_ENABLED_HOLDS: assert property (@(posedge clk_cpu) disable iff (!por_n)
    (mon1_low && mon1_en) |-> !rst_core_n); // R2

  AST_CKSEL_IN_RESET: assert property (@(posedge clk_cpu) disable iff (!por_n)
    !rst_core_n |-> clk_slow_div8); // R5

  AST_PRIMARY_CLEARS: assert property (@(posedge clk_cpu) disable iff (!por_n)
    mon0_low |-> (stat_rd == 3'b000 && pmode == '0)); // R6

  AST_KEEP_INSIDE_CORE: assert property (@(posedge clk_cpu) disable iff (!por_n)
    !rst_keep_n |-> !rst_core_n); // R8

  AST_MODE_FROZEN: assert property (@(posedge clk_cpu) disable iff (!por_n)
    (!rst_core_n && $past(!rst_core_n) && rst_keep_n && $past(rst_keep_n))
      |-> $stable(pmode)); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk_cpu) disable iff (!por_n)
    start_fetch |=> !start_fetch); // R10

  AST_START_ON_RELEASE: assert property (@(posedge clk_cpu) disable iff (!por_n)
    start_fetch |-> $rose(rst_core_n)); // R10

endmodule

bind supply_rst_seq supply_rst_seq_chk #(.PM_W(PM_W)) u_chk (
  .clk_cpu       (clk_cpu),
  .por_n         (por_n),
  .mon0_low      (mon0_low),
  .mon1_low      (mon1_low),
  .mon1_en       (mon1_en),
  .rst_core_n    (rst_core_n),
  .rst_keep_n    (rst_keep_n),
  .start_fetch   (start_fetch),
  .clk_slow_div8 (clk_slow_div8),
  .stat_rd       (stat_rd),
  .pmode         (pmode)
);

// File: tb/supply_rst_seq_bench.sv
module supply_rst_seq_bench;

  localparam int PM_W    = 2;
  localparam int SEC_MIN = 68;   // 8 stabilization + 60 tail CPU cycles
  localparam int SEC_MAX = 78;
  localparam int P0_MIN  = 128;  // 32 osc periods of 16 ns in 4 ns CPU cycles
  localparam int P0_MAX  = 152;

  logic clk_osc = 1'b0;
  logic clk_cpu = 1'b0;
  logic por_n, mon0_low, mon1_low, mon2_low, mon1_en, mon2_en;
  logic clk_sel_wr, clk_sel_d, stat_wr, pm_wr;
  logic [2:0] stat_wdata;
  logic [PM_W-1:0] pm_wdata;
  logic rst_core_n, rst_keep_n, start_fetch, clk_slow_div8;
  logic [2:0] stat_rd;
  logic [PM_W-1:0] pmode;

  always #2 clk_cpu = ~clk_cpu;   // 250 MHz
  always #8 clk_osc = ~clk_osc;

  supply_rst_seq u_supply_rst_seq (
    .clk_osc(clk_osc), .clk_cpu(clk_cpu), .por_n(por_n),
    .mon0_low(mon0_low), .mon1_low(mon1_low), .mon2_low(mon2_low),
    .mon1_en(mon1_en), .mon2_en(mon2_en),
    .clk_sel_wr(clk_sel_wr), .clk_sel_d(clk_sel_d),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .pm_wr(pm_wr), .pm_wdata(pm_wdata),
    .rst_core_n(rst_core_n), .rst_keep_n(rst_keep_n),
    .start_fetch(start_fetch), .clk_slow_div8(clk_slow_div8),
    .stat_rd(stat_rd), .pmode(pmode)
  );

  typedef struct {
    logic [2:0]      st;
    logic [PM_W-1:0] pm;
    logic            ck;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [2:0] st, input logic [PM_W-1:0] pm,
                          input logic ck, input string tag);
    exp_t e;
    e.st = st; e.pm = pm; e.ck = ck; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: every start pulse pops one expectation.
  always @(negedge clk_cpu) begin
    if (por_n === 1'b1 && start_fetch === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected start pulse", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(stat_rd == e.st, e.tag, "status at start", 8'(stat_rd), 8'(e.st));
        chk(pmode == e.pm, e.tag, "pmode at start", 8'(pmode), 8'(e.pm));
        chk(clk_slow_div8 == e.ck, "R5", "clock select at start",
            8'(clk_slow_div8), 8'(e.ck));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_cpu);
  endtask

  // Called at the negedge where the trigger was just removed.
  task automatic release_window(input int lo, input int hi, input string req);
    int k;
    cyc(lo);
    chk(rst_core_n == 1'b0, req, "released too early", 8'(rst_core_n), 8'd0);
    k = lo;
    while (!rst_core_n && k < hi) begin
      @(negedge clk_cpu);
      k++;
    end
    chk(rst_core_n == 1'b1, req, "released too late", 8'(rst_core_n), 8'd1);
    @(negedge clk_cpu);
    chk(start_fetch == 1'b0, "R10", "start pulse longer than one cycle",
        8'(start_fetch), 8'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_cpu);
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    bit saw_low;
    por_n = 0; mon0_low = 0; mon1_low = 0; mon2_low = 0;
    mon1_en = 0; mon2_en = 0; clk_sel_wr = 0; clk_sel_d = 0;
    stat_wr = 0; stat_wdata = '0; pm_wr = 0; pm_wdata = '0;
    cyc(5);
    chk(rst_core_n == 0, "R6", "core reset at power-on", 8'(rst_core_n), 8'd0);
    chk(rst_keep_n == 0, "R6", "keep reset at power-on", 8'(rst_keep_n), 8'd0);
    chk(clk_slow_div8 == 1, "R5", "clock select at power-on", 8'(clk_slow_div8), 8'd1);
    chk(stat_rd == 3'b000, "R6", "status at power-on", 8'(stat_rd), 8'd0);
    push_exp(3'b000, 2'b00, 1'b1, "R6");
    por_n = 1;
    release_window(0, 300, "R3");

    // Software writes out of reset: R9, R5, R8
    pm_wr = 1; pm_wdata = 2'b10; stat_wr = 1; stat_wdata = 3'b001;
    clk_sel_wr = 1; clk_sel_d = 0;
    cyc(1);
    pm_wr = 0; stat_wr = 0; clk_sel_wr = 0;
    cyc(1);
    chk(pmode == 2'b10, "R9", "pmode write", 8'(pmode), 8'h2);
    chk(stat_rd == 3'b001, "R9", "warm bit set by write", 8'(stat_rd), 8'h1);
    chk(clk_slow_div8 == 0, "R5", "clock select write", 8'(clk_slow_div8), 8'd0);

    // Disabled secondaries: R2
    saw_low = 0;
    mon1_low = 1; mon2_low = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_cpu);
      if (!rst_core_n) saw_low = 1;
    end
    mon1_low = 0; mon2_low = 0;
    cyc(4);
    chk(saw_low == 0, "R2", "reset from disabled monitor", 8'(saw_low), 8'd0);
    chk(stat_rd == 3'b001, "R2", "flag from disabled monitor", 8'(stat_rd), 8'h1);

    // Enabled secondary 1: R1/R2 immediate, R4 timing, R7 flag, R8 retention
    mon1_en = 1; mon1_low = 1;
    #1;
    chk(rst_core_n == 0, "R2", "enabled monitor reset not immediate", 8'(rst_core_n), 8'd0);
    chk(rst_keep_n == 1, "R8", "keep reset during secondary", 8'(rst_keep_n), 8'd1);
    push_exp(3'b011, 2'b10, 1'b1, "R7");
    cyc(10);
    mon1_low = 0;
    release_window(SEC_MIN, SEC_MAX, "R4");

    // Flag write semantics: R9
    stat_wr = 1; stat_wdata = 3'b101;
    cyc(1); stat_wr = 0; cyc(1);
    chk(stat_rd == 3'b001, "R9", "write 0 clears flag", 8'(stat_rd), 8'h1);
    stat_wr = 1; stat_wdata = 3'b110;
    cyc(1); stat_wr = 0; cyc(1);
    chk(stat_rd == 3'b001, "R9", "write 1 to flags ignored", 8'(stat_rd), 8'h1);

    // Secondary 2 with writes during reset: R7, R9, R4
    mon2_en = 1; mon2_low = 1;
    push_exp(3'b101, 2'b10, 1'b1, "R9");
    cyc(3);
    stat_wr = 1; stat_wdata = 3'b000; pm_wr = 1; pm_wdata = 2'b11;
    cyc(1);
    stat_wr = 0; pm_wr = 0;
    cyc(5);
    mon2_low = 0;
    release_window(SEC_MIN, SEC_MAX, "R4");

    // Retrigger during count: R11
    mon1_low = 1;
    push_exp(3'b111, 2'b10, 1'b1, "R11");
    cyc(5);
    mon1_low = 0;
    cyc(40);
    chk(rst_core_n == 0, "R11", "reset mid-count", 8'(rst_core_n), 8'd0);
    mon1_low = 1;
    cyc(3);
    mon1_low = 0;
    release_window(SEC_MIN, SEC_MAX, "R11");

    // Primary with a secondary active together: R12, R1, R3, R6
    mon1_low = 1;
    cyc(3);
    mon0_low = 1;
    #1;
    chk(rst_keep_n == 0, "R1", "primary keep reset not immediate", 8'(rst_keep_n), 8'd0);
    chk(stat_rd == 3'b000, "R12", "primary clears status", 8'(stat_rd), 8'd0);
    push_exp(3'b000, 2'b00, 1'b1, "R12");
    cyc(5);
    mon1_low = 0;
    cyc(5);
    mon0_low = 0;
    release_window(P0_MIN, P0_MAX, "R3");

    // Primary with enables low: R1
    mon1_en = 0; mon2_en = 0;
    @(negedge clk_cpu);
    mon0_low = 1;
    #1;
    chk(rst_core_n == 0, "R1", "primary core reset not immediate", 8'(rst_core_n), 8'd0);
    push_exp(3'b000, 2'b00, 1'b1, "R6");
    cyc(4);
    mon0_low = 0;
    release_window(P0_MIN, P0_MAX, "R3");

    cyc(3);
    chk(exp_q.size() == 0, "R10", "missing start pulses", 8'(exp_q.size()), 8'd0);
    done_flag = 1;
    finish_run();
  end

endmodule